// File: doc/BRIEF.md
# ADC Sample Output Demultiplexer and Formatter

This block sits between a converter's sample stream and the chip's data pins. Each clock with the sample enable high delivers one signed raw value. The block saturates that value to a 10-bit code and raises an over-range flag when it clips. It then presents the code, either in offset binary or in two's complement, on one of several output arrangements.

In the full-rate arrangements, every sample lands on bus A at the sample rate. In the two split arrangements, consecutive samples alternate between bus A and bus B, so that each bus runs at half rate. The two buses either change together as a pair, or take turns on alternate samples. A half-rate output clock marks the moments when data is valid. The format select is latched only at the start of a pair, so a pair never mixes formats.

Top module: `adcfmt_demux`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `bus_a`, `bus_b`, `ovf_a`, `ovf_b` and `out_clk` to 0, and clears the A/B phase. The first valid sample after reset goes to bus A in every mode.
- R2: With `mode_sel` 0 or 3 (full rate), each valid sample appears on `bus_a`/`ovf_a` one cycle after its clock edge. `bus_b`/`ovf_b` keep their values, and `out_clk` equals `smp_vld` delayed by one cycle.
- R3: With `mode_sel` 2 (interleaved), valid samples go alternately to bus A then bus B, and only one bus changes per edge. `out_clk` becomes 1 after an A update and 0 after a B update.
- R4: With `mode_sel` 1 (simultaneous), the first sample of a pair is held internally. On the second sample, `bus_a` takes the first and `bus_b` the second on the same edge. `out_clk` becomes 1 after the pair update and 0 after the first half.
- R5: In the split modes, a cycle with `smp_vld` low changes neither bus, nor `out_clk`, nor the phase.
- R6: `smp_raw` is a 12-bit two's complement value. For -512..511 the offset-binary code is raw+512 (0x200 is mid-scale, 0x3FF is +full scale, 0x000 is -full scale), and the overflow bit is 0.
- R7: A raw value above 511 gives overflow 1 and code 0x3FF (0x1FF in two's complement). A raw value below -512 gives overflow 1 and code 0x000 (0x200 in two's complement).
- R8: With `fmt_twos` = 1, the emitted code is the offset-binary code with bit 9 inverted.
- R9: In the split modes, `fmt_twos` is sampled only with the first sample of a pair, and the second sample uses the same format. In full-rate modes it is sampled with every sample.
- R10: Each bus's overflow bit belongs to the sample on that same bus and is updated on the same edge.
- R11: A change of `mode_sel` from one cycle to the next clears the phase and drops any half-built pair. A valid sample in the changing cycle is treated as a first (bus A) sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample enable; a sample is taken on each edge where it is high |
| smp_raw | input | 12 | Signed raw sample, may exceed the 10-bit range |
| mode_sel | input | 2 | 0 full rate, 1 split simultaneous, 2 split interleaved, 3 full rate |
| fmt_twos | input | 1 | 1 selects two's complement, 0 offset binary |
| bus_a | output | 10 | Output bus A |
| ovf_a | output | 1 | Over-range flag for bus A |
| bus_b | output | 10 | Output bus B |
| ovf_b | output | 1 | Over-range flag for bus B |
| out_clk | output | 1 | Output data clock (half rate in split modes) |

## Verification
On every cycle, the assertions check the following: in simultaneous mode the two buses update only together, and in interleaved mode never both at once. The phase flips on each split-mode sample. In full-rate modes bus B stays idle and the output clock follows the enable. Idle cycles hold the split-mode outputs, and a flagged code always sits at a full-scale value. The exact saturated and formatted values are shown only by the bench's scenarios. So are the pairing of first and second samples, the point at which the format is latched within a pair, and the realignment after a mode change. The bench compares all of these against its own reference computed from the requirements.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;
  localparam int unsigned DEF_RAW_W  = 12;
  localparam int unsigned DEF_CODE_W = 10;

  typedef enum logic [1:0] {
    OM_FULL   = 2'd0,
    OM_SIMUL  = 2'd1,
    OM_INTER  = 2'd2,
    OM_SERIAL = 2'd3
  } out_mode_e;
endpackage

// File: rtl/adcfmt_encode.sv
module adcfmt_encode #(
  parameter int unsigned RAW_W  = adcfmt_pkg::DEF_RAW_W,
  parameter int unsigned CODE_W = adcfmt_pkg::DEF_CODE_W
) (
  input  logic [RAW_W-1:0]  raw,
  input  logic              fmt_twos,
  output logic [CODE_W-1:0] code,
  output logic              ovf
);
  localparam int POS_FS = (1 << (CODE_W - 1)) - 1;
  localparam int NEG_FS = -(1 << (CODE_W - 1));

  // returns {overflow, offset-binary code}
  function automatic logic [CODE_W:0] sat_offset(input logic [RAW_W-1:0] r);
    int v;
    logic [CODE_W-1:0] c;
    v = int'($signed(r));
    if (v > POS_FS) return {1'b1, {CODE_W{1'b1}}};
    if (v < NEG_FS) return {1'b1, {CODE_W{1'b0}}};
    c = r[CODE_W-1:0];
    c[CODE_W-1] = ~c[CODE_W-1];
    return {1'b0, c};
  endfunction

  function automatic logic [CODE_W-1:0] to_twos(input logic [CODE_W-1:0] c);
    return {~c[CODE_W-1], c[CODE_W-2:0]};
  endfunction

  logic [CODE_W:0] sat;

  always_comb begin
    sat  = sat_offset(raw);
    ovf  = sat[CODE_W];
    code = fmt_twos ? to_twos(sat[CODE_W-1:0]) : sat[CODE_W-1:0];
  end
endmodule

// File: rtl/adcfmt_phase.sv
module adcfmt_phase (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  input  logic       smp_vld,
  input  logic       fmt_twos,
  output logic       mode_fr,
  output logic       mode_simul,
  output logic       mode_inter,
  output logic       mode_chg,
  output logic       slot_b,
  output logic       ph_q,
  output logic       fmt_use
);
  import adcfmt_pkg::*;

  out_mode_e mode_now;
  logic [1:0] mode_q;
  logic       fmt_q;

  always_comb begin
    mode_now   = out_mode_e'(mode_sel);
    mode_fr    = (mode_now == OM_FULL) || (mode_now == OM_SERIAL);
    mode_simul = (mode_now == OM_SIMUL);
    mode_inter = (mode_now == OM_INTER);
    mode_chg   = (mode_sel != mode_q);
    slot_b     = ph_q & ~mode_chg;
    fmt_use    = (mode_fr | ~slot_b) ? fmt_twos : fmt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= mode_sel;
      ph_q   <= 1'b0;
      fmt_q  <= fmt_twos;
    end else begin
      mode_q <= mode_sel;
      if (mode_fr)      ph_q <= 1'b0;
      else if (smp_vld) ph_q <= ~slot_b;
      else              ph_q <= slot_b;
      if (smp_vld)      fmt_q <= fmt_use;
    end
  end
endmodule

// File: rtl/adcfmt_steer.sv
module adcfmt_steer #(
  parameter int unsigned CODE_W = adcfmt_pkg::DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_fr,
  input  logic              mode_simul,
  input  logic              mode_inter,
  input  logic              smp_vld,
  input  logic              slot_b,
  input  logic [CODE_W-1:0] code,
  input  logic              ovf,
  output logic              upd_a,
  output logic              upd_b,
  output logic [CODE_W-1:0] bus_a,
  output logic              ovf_a,
  output logic [CODE_W-1:0] bus_b,
  output logic              ovf_b,
  output logic              out_clk
);
  logic [CODE_W-1:0] pend_code;
  logic              pend_ovf;
  logic              pend_ld;

  always_comb begin
    upd_a   = smp_vld & (mode_fr | (mode_inter & ~slot_b) | (mode_simul & slot_b));
    upd_b   = smp_vld & slot_b & (mode_inter | mode_simul);
    pend_ld = smp_vld & mode_simul & ~slot_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_a     <= '0;
      ovf_a     <= 1'b0;
      bus_b     <= '0;
      ovf_b     <= 1'b0;
      pend_code <= '0;
      pend_ovf  <= 1'b0;
      out_clk   <= 1'b0;
    end else begin
      if (pend_ld) begin
        pend_code <= code;
        pend_ovf  <= ovf;
      end
      if (upd_a) begin
        bus_a <= mode_simul ? pend_code : code;
        ovf_a <= mode_simul ? pend_ovf  : ovf;
      end
      if (upd_b) begin
        bus_b <= code;
        ovf_b <= ovf;
      end
      if (mode_fr)      out_clk <= smp_vld;
      else if (smp_vld) out_clk <= mode_inter ? ~slot_b : slot_b;
    end
  end
endmodule

// File: rtl/adcfmt_demux.sv
module adcfmt_demux #(
  parameter int unsigned RAW_W  = adcfmt_pkg::DEF_RAW_W,
  parameter int unsigned CODE_W = adcfmt_pkg::DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_vld,
  input  logic [RAW_W-1:0]  smp_raw,
  input  logic [1:0]        mode_sel,
  input  logic              fmt_twos,
  output logic [CODE_W-1:0] bus_a,
  output logic              ovf_a,
  output logic [CODE_W-1:0] bus_b,
  output logic              ovf_b,
  output logic              out_clk
);
  logic mode_fr, mode_simul, mode_inter, mode_chg;
  logic slot_b, ph_q, fmt_use;
  logic [CODE_W-1:0] enc_code;
  logic enc_ovf;
  logic upd_a, upd_b;

  adcfmt_phase u_phase (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .smp_vld(smp_vld),
    .fmt_twos(fmt_twos), .mode_fr(mode_fr), .mode_simul(mode_simul),
    .mode_inter(mode_inter), .mode_chg(mode_chg), .slot_b(slot_b),
    .ph_q(ph_q), .fmt_use(fmt_use)
  );

  adcfmt_encode #(.RAW_W(RAW_W), .CODE_W(CODE_W)) u_enc (
    .raw(smp_raw), .fmt_twos(fmt_use), .code(enc_code), .ovf(enc_ovf)
  );

  adcfmt_steer #(.CODE_W(CODE_W)) u_steer (
    .clk(clk), .rst(rst), .mode_fr(mode_fr), .mode_simul(mode_simul),
    .mode_inter(mode_inter), .smp_vld(smp_vld), .slot_b(slot_b),
    .code(enc_code), .ovf(enc_ovf), .upd_a(upd_a), .upd_b(upd_b),
    .bus_a(bus_a), .ovf_a(ovf_a), .bus_b(bus_b), .ovf_b(ovf_b),
    .out_clk(out_clk)
  );
endmodule

// File: rtl/adcfmt_chk.sv
module adcfmt_chk #(
  parameter int unsigned CODE_W = adcfmt_pkg::DEF_CODE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              smp_vld,
  input logic              mode_fr,
  input logic              mode_simul,
  input logic              mode_inter,
  input logic              slot_b,
  input logic              ph_q,
  input logic              upd_a,
  input logic              upd_b,
  input logic [CODE_W-1:0] bus_a,
  input logic              ovf_a,
  input logic [CODE_W-1:0] bus_b,
  input logic              ovf_b,
  input logic              out_clk
);
  AST_SIMUL_PAIR: assert property (@(posedge clk) disable iff (rst)
    mode_simul |-> (upd_a == upd_b)); // R4
  AST_INTER_ONE_BUS: assert property (@(posedge clk) disable iff (rst)
    mode_inter |-> !(upd_a && upd_b)); // R3
  AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (rst)
    ((mode_simul || mode_inter) && smp_vld) |=> (ph_q == !$past(slot_b))); // R3
  AST_FR_B_IDLE: assert property (@(posedge clk) disable iff (rst)
    mode_fr |=> ($stable(bus_b) && $stable(ovf_b))); // R2
  AST_FR_CLK_HI: assert property (@(posedge clk) disable iff (rst)
    (mode_fr && smp_vld) |=> out_clk); // R2
  AST_FR_CLK_LO: assert property (@(posedge clk) disable iff (rst)
    (mode_fr && !smp_vld) |=> !out_clk); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((mode_simul || mode_inter) && !smp_vld) |=>
      ($stable(bus_a) && $stable(bus_b) && $stable(out_clk))); // R5
  AST_SAT_A: assert property (@(posedge clk) disable iff (rst)
    ovf_a |-> ((&bus_a[CODE_W-2:0]) || !(|bus_a[CODE_W-2:0]))); // R7
  AST_SAT_B: assert property (@(posedge clk) disable iff (rst)
    ovf_b |-> ((&bus_b[CODE_W-2:0]) || !(|bus_b[CODE_W-2:0]))); // R7
endmodule

bind adcfmt_demux adcfmt_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .smp_vld(smp_vld), .mode_fr(mode_fr),
  .mode_simul(mode_simul), .mode_inter(mode_inter), .slot_b(slot_b),
  .ph_q(ph_q), .upd_a(upd_a), .upd_b(upd_b), .bus_a(bus_a), .ovf_a(ovf_a),
  .bus_b(bus_b), .ovf_b(ovf_b), .out_clk(out_clk)
);

// File: tb/tb_adcfmt_demux.sv
`timescale 1ns/1ps
module tb_adcfmt_demux;
  logic clk = 1'b0;
  logic rst, smp_vld, fmt_twos;
  logic [11:0] smp_raw;
  logic [1:0]  mode_sel;
  logic [9:0]  bus_a, bus_b;
  logic        ovf_a, ovf_b, out_clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string tag = "R1";

  // reference state
  logic [9:0] e_a, e_b, e_pc;
  logic       e_oa, e_ob, e_po, e_clk, e_ph, e_fq;
  logic [1:0] e_mq;

  always #5 clk = ~clk;

  adcfmt_demux dut (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_raw(smp_raw),
    .mode_sel(mode_sel), .fmt_twos(fmt_twos), .bus_a(bus_a), .ovf_a(ovf_a),
    .bus_b(bus_b), .ovf_b(ovf_b), .out_clk(out_clk)
  );

  // R6 R7 R8: expected {ovf, code} from integer arithmetic
  function automatic logic [10:0] ref_code(input logic [11:0] r, input logic tw);
    int v, off;
    logic o;
    v = (r[11]) ? int'(r) - 4096 : int'(r);
    o = 1'b0;
    if (v > 511) begin off = 1023; o = 1'b1; end
    else if (v < -512) begin off = 0; o = 1'b1; end
    else off = v + 512;
    if (tw) off = off ^ 512;
    return {o, off[9:0]};
  endfunction

  task automatic model_edge();
    logic ph, f, fr;
    logic [10:0] oc;
    if (rst) begin
      e_a = 0; e_b = 0; e_pc = 0; e_oa = 0; e_ob = 0; e_po = 0;
      e_clk = 0; e_ph = 0; e_fq = fmt_twos; e_mq = mode_sel;
      return;
    end
    ph = (mode_sel != e_mq) ? 1'b0 : e_ph;
    e_mq = mode_sel;
    fr = (mode_sel == 2'd0) || (mode_sel == 2'd3);
    if (smp_vld) begin
      f = (fr || !ph) ? fmt_twos : e_fq;
      e_fq = f;
      oc = ref_code(smp_raw, f);
      if (fr) begin
        e_a = oc[9:0]; e_oa = oc[10]; e_clk = 1; e_ph = 0;
      end else if (mode_sel == 2'd2) begin
        if (!ph) begin e_a = oc[9:0]; e_oa = oc[10]; e_clk = 1; end
        else     begin e_b = oc[9:0]; e_ob = oc[10]; e_clk = 0; end
        e_ph = !ph;
      end else begin
        if (!ph) begin e_pc = oc[9:0]; e_po = oc[10]; e_clk = 0; end
        else begin
          e_a = e_pc; e_oa = e_po; e_b = oc[9:0]; e_ob = oc[10]; e_clk = 1;
        end
        e_ph = !ph;
      end
    end else begin
      if (fr) begin e_clk = 0; e_ph = 0; end
      else e_ph = ph;
    end
  endtask

  task automatic compare();
    checks++;
    if (bus_a !== e_a || ovf_a !== e_oa) begin
      fails++;
      $display("FAIL %s bus_a/ovf_a got %h/%b exp %h/%b", tag, bus_a, ovf_a, e_a, e_oa);
    end
    checks++;
    if (bus_b !== e_b || ovf_b !== e_ob) begin
      fails++;
      $display("FAIL %s bus_b/ovf_b got %h/%b exp %h/%b", tag, bus_b, ovf_b, e_b, e_ob);
    end
    checks++;
    if (out_clk !== e_clk) begin
      fails++;
      $display("FAIL %s out_clk got %b exp %b", tag, out_clk, e_clk);
    end
  endtask

  task automatic step(input logic r, input logic v, input logic [11:0] raw,
                      input logic [1:0] m, input logic tw);
    rst = r; smp_vld = v; smp_raw = raw; mode_sel = m; fmt_twos = tw;
    model_edge();
    @(posedge clk);
    #1;
    compare();
  endtask

  function automatic logic [11:0] pick_raw();
    case ($urandom_range(0, 5))
      0: return 12'($urandom_range(512, 2047));
      1: return 12'(-int'($urandom_range(513, 2048)));
      2: return 12'd511;
      3: return 12'hE00;
      default: return 12'($urandom);
    endcase
  endfunction

  string mtag[4] = '{"R2", "R4", "R3", "R2"};

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; smp_vld = 0; smp_raw = 0; mode_sel = 0; fmt_twos = 0;
    #1;
    tag = "R1";
    step(1, 0, 0, 0, 0);
    step(1, 1, 12'd100, 2, 0);
    step(0, 0, 0, 2, 0);                 // R1 reset state held
    step(0, 1, 12'd5, 2, 0);             // R1 first sample to bus A
    step(0, 1, 12'd6, 2, 0);

    tag = "R6";
    step(1, 0, 0, 0, 0);
    step(0, 1, 12'd0, 0, 0);             // 0x200
    step(0, 1, 12'd511, 0, 0);           // 0x3FF
    step(0, 1, 12'hE00, 0, 0);           // -512 -> 0x000
    tag = "R7";
    step(0, 1, 12'd600, 0, 0);
    step(0, 1, 12'h800, 0, 0);
    step(0, 1, 12'd2047, 0, 1);
    step(0, 1, 12'hD00, 0, 1);
    tag = "R8";
    step(0, 1, 12'd0, 3, 1);
    step(0, 1, 12'd1, 3, 1);
    step(0, 1, 12'hFFF, 3, 1);
    tag = "R2";
    step(0, 0, 12'd3, 0, 0);
    step(0, 1, 12'd3, 0, 0);

    tag = "R9";
    step(1, 0, 0, 1, 0);
    step(0, 1, 12'd10, 1, 0);
    step(0, 1, 12'd20, 1, 1);            // second half keeps offset binary
    step(0, 1, 12'd30, 1, 1);
    step(0, 1, 12'd40, 1, 0);            // keeps two's complement
    tag = "R4";
    step(0, 1, 12'd50, 1, 0);
    step(0, 1, 12'd60, 1, 0);

    tag = "R10";
    step(1, 0, 0, 2, 0);
    step(0, 1, 12'd7, 2, 0);
    step(0, 1, 12'd900, 2, 0);           // overflow lands on B only
    step(0, 1, 12'hC00, 2, 0);

    tag = "R5";
    step(0, 0, 12'd999, 2, 1);
    step(0, 0, 12'd1, 2, 0);
    step(0, 1, 12'd8, 2, 0);

    tag = "R11";
    step(0, 1, 12'd9, 1, 0);             // mode change: first of a pair
    step(0, 1, 12'd11, 1, 0);
    step(0, 1, 12'd12, 1, 0);
    step(0, 1, 12'd13, 2, 0);            // half pair dropped, goes to A
    step(0, 1, 12'd14, 2, 0);

    for (int blk = 0; blk < 60; blk++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      tag = mtag[m];
      if ($urandom_range(0, 4) == 0) step(1, 0, 0, m, 1'($urandom));
      for (int k = 0; k < 40; k++)
        step(0, ($urandom_range(0, 3) != 0), pick_raw(), m, 1'($urandom));
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired exp completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule